// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator

This block watches a running calendar clock and raises an alarm when the time reaches a programmed setting. The clock supplies BCD minute, hour and day-of-month values, a day-of-week index from 0 to 6, and a strobe that pulses for one cycle each time the minute digit rolls over. When the strobe pulses, the time inputs already carry the new time. A host programs three alarm registers and a configuration register through a single write port. It clears the alarm flag through a separate flag write.

Each of the three alarm registers has a don't-care bit in bit 7, and that bit uses negative logic. The third register has two readings, chosen by a configuration bit: a mask of weekdays, or a BCD day of the month. The block compares the time only on a rollover of the lowest digit that is still being compared. The compare takes place a fixed number of cycles after the strobe, and an alarm-register write during that window cancels it. A match sets a sticky flag. The interrupt line is active low, and when it is disabled it is released and reads as 1.

Top module: `tod_alarm`

## Requirements
- R1: After reset, the flag output is 0 and the interrupt output is 1. All three alarm registers reset to 0x80, and the configuration register resets to 0.
- R2: Register addresses are 0 for the minute alarm (BCD in bits 6:0), 1 for the hour alarm (BCD in bits 5:0) and 2 for the shared week/day alarm. Address 3 is configuration: bit 0 is the week/day select and bit 1 is the interrupt enable. A qualifying rollover on which every compared field equals the time sets the flag on the WIN_CYC-th clock edge after the edge that samples the strobe.
- R3: When bit 7 of an alarm register is 1, its field is ignored. When bit 7 is 0, the field is compared.
- R4: With select = 0, bits 6:0 of register 2 form a weekday mask, where bit n stands for day n. A rollover on any day whose bit is set matches, and a rollover on any other day does not.
- R5: With select = 1, bits 5:0 of register 2 hold a BCD day of the month, and it is compared against the day-of-month input.
- R6: A compare is evaluated only on a rollover of the lowest compared digit. If the minute field is compared, every strobe counts. If the lowest compared field is the hour, only strobes with minute 00 count. If the lowest compared field is week/day, only strobes with minute 00 and hour 00 count.
- R7: When all three fields are don't-care, every strobe sets the flag.
- R8: The flag is never set without a strobe. Writing alarm values that equal the current time does not set it.
- R9: A write to address 0, 1 or 2 on any edge from the strobe edge through the compare edge cancels that compare.
- R10: The flag stays set until a flag write of 0 clears it. A flag write of 1 has no effect.
- R11: A flag write of 0 on the same edge that a match would set the flag leaves the flag at 0.
- R12: The interrupt output is 0 exactly when the interrupt enable is 1 and the flag is 1. Otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cur_min_i | input | 7 | Current minute, BCD |
| cur_hour_i | input | 6 | Current hour, BCD |
| cur_wday_i | input | 3 | Current day of week, 0 to 6 |
| cur_mday_i | input | 6 | Current day of month, BCD |
| carry_i | input | 1 | One-cycle strobe on each minute rollover |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| flag_we_i | input | 1 | Flag write strobe |
| flag_wdata_i | input | 1 | Flag write value (only 0 has an effect) |
| match_flag_o | output | 1 | Sticky alarm flag |
| irq_no | output | 1 | Interrupt request, active low; 1 when released |

## Verification
The embedded assertions check on every cycle that the flag holds unless it is cleared, falls after every clear, rises only after a compare fire, and that no compare fires during an alarm-register write. They also check that a disabled interrupt stays released. The field encodings need the bench's scenarios: don't-care polarity, weekday masks with several days, day-of-month mode and the lowest-digit rollover rule. The same holds for cancellation by a write inside the window, the race between a clear and a set, and the rule that a time equal to the alarm alone sets nothing.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
  localparam int REG_W   = 8;
  localparam int DC_BIT  = 7;
  localparam int MIN_W   = 7;
  localparam int HOUR_W  = 6;
  localparam int MDAY_W  = 6;
  localparam int WDAY_W  = 3;
  localparam int NDAYS   = 7;
  localparam int ADDR_W  = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_MIN  = 2'd0,
    ADDR_HOUR = 2'd1,
    ADDR_WD   = 2'd2,
    ADDR_CFG  = 2'd3
  } addr_e;

  typedef struct packed {
    logic [REG_W-1:0] min_a;
    logic [REG_W-1:0] hour_a;
    logic [REG_W-1:0] wd_a;
    logic             wd_sel;
    logic             irq_en;
  } alarm_cfg_t;

  localparam logic [REG_W-1:0] ALARM_RST = 8'h80;
endpackage

// File: rtl/tod_alarm_regs.sv
module tod_alarm_regs
  import tod_alarm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output alarm_cfg_t        cfg_o,
  output logic              alarm_wr_o
);
  alarm_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.min_a  <= ALARM_RST;
      cfg_q.hour_a <= ALARM_RST;
      cfg_q.wd_a   <= ALARM_RST;
      cfg_q.wd_sel <= 1'b0;
      cfg_q.irq_en <= 1'b0;
    end else if (we_i) begin
      unique case (addr_e'(addr_i))
        ADDR_MIN:  cfg_q.min_a  <= wdata_i;
        ADDR_HOUR: cfg_q.hour_a <= wdata_i;
        ADDR_WD:   cfg_q.wd_a   <= wdata_i;
        ADDR_CFG: begin
          cfg_q.wd_sel <= wdata_i[0];
          cfg_q.irq_en <= wdata_i[1];
        end
        default: ;
      endcase
    end
  end

  assign cfg_o      = cfg_q;
  assign alarm_wr_o = we_i && (addr_e'(addr_i) != ADDR_CFG);

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^wdata_i[REG_W-1:2];
endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
  import tod_alarm_pkg::*;
(
  input  alarm_cfg_t        cfg_i,
  input  logic [MIN_W-1:0]  cur_min_i,
  input  logic [HOUR_W-1:0] cur_hour_i,
  input  logic [WDAY_W-1:0] cur_wday_i,
  input  logic [MDAY_W-1:0] cur_mday_i,
  input  logic              carry_i,
  output logic              strobe_o,
  output logic              match_o
);
  logic dc_min, dc_hour, dc_wd;
  logic min_eq, hour_eq, wday_eq, mday_eq, wd_eq;
  logic [NDAYS-1:0] day_sel;

  assign dc_min  = cfg_i.min_a[DC_BIT];
  assign dc_hour = cfg_i.hour_a[DC_BIT];
  assign dc_wd   = cfg_i.wd_a[DC_BIT];

  assign min_eq  = cfg_i.min_a[MIN_W-1:0]   == cur_min_i;
  assign hour_eq = cfg_i.hour_a[HOUR_W-1:0] == cur_hour_i;
  assign mday_eq = cfg_i.wd_a[MDAY_W-1:0]   == cur_mday_i;

  for (genvar d = 0; d < NDAYS; d++) begin : g_day
    assign day_sel[d] = (cur_wday_i == WDAY_W'(d));
  end

  assign wday_eq = |(cfg_i.wd_a[NDAYS-1:0] & day_sel);
  assign wd_eq   = cfg_i.wd_sel ? mday_eq : wday_eq;

  assign match_o = (dc_min || min_eq) && (dc_hour || hour_eq) && (dc_wd || wd_eq);

  // rollover of the lowest compared digit
  logic min_zero, hour_zero, digit_ok;
  assign min_zero  = (cur_min_i == '0);
  assign hour_zero = (cur_hour_i == '0);

  always_comb begin
    if (!dc_min)       digit_ok = 1'b1;
    else if (!dc_hour) digit_ok = min_zero;
    else if (!dc_wd)   digit_ok = min_zero && hour_zero;
    else               digit_ok = 1'b1;
  end

  assign strobe_o = carry_i && digit_ok;

  logic unused_hour_bit;
  assign unused_hour_bit = cfg_i.hour_a[6] ^ cfg_i.irq_en;
endmodule

// File: rtl/tod_alarm_window.sv
module tod_alarm_window #(
  parameter int WIN_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic alarm_wr_i,
  input  logic match_i,
  output logic fire_o
);
  localparam int CNT_W = (WIN_CYC < 2) ? 1 : $clog2(WIN_CYC);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_CYC - 1);

  logic             pend_q, kill_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      kill_q <= 1'b0;
      cnt_q  <= '0;
    end else if (strobe_i) begin
      pend_q <= 1'b1;
      kill_q <= alarm_wr_i;
      cnt_q  <= '0;
    end else if (pend_q) begin
      kill_q <= kill_q || alarm_wr_i;
      if (cnt_q == LAST) begin
        pend_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign fire_o = pend_q && (cnt_q == LAST) && !kill_q && !alarm_wr_i && match_i;

  a_r9_no_fire_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_wr_i |-> !fire_o);
endmodule

// File: rtl/tod_alarm_flag.sv
module tod_alarm_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic flag_we_i,
  input  logic flag_wdata_i,
  input  logic irq_en_i,
  output logic flag_o,
  output logic irq_no
);
  logic flag_q, clr;
  assign clr = flag_we_i && !flag_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (clr)    flag_q <= 1'b0;  // clear wins over a same-edge match
    else if (fire_i) flag_q <= 1'b1;
  end

  assign flag_o = flag_q;
  assign irq_no = !(irq_en_i && flag_q);

  a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !clr |=> flag_q);
  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> !flag_q);
  a_r8_set_needs_fire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(fire_i));
endmodule

// File: rtl/tod_alarm.sv
module tod_alarm
  import tod_alarm_pkg::*;
#(
  parameter int WIN_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MIN_W-1:0]  cur_min_i,
  input  logic [HOUR_W-1:0] cur_hour_i,
  input  logic [WDAY_W-1:0] cur_wday_i,
  input  logic [MDAY_W-1:0] cur_mday_i,
  input  logic              carry_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  input  logic              flag_we_i,
  input  logic              flag_wdata_i,
  output logic              match_flag_o,
  output logic              irq_no
);
  alarm_cfg_t cfg;
  logic alarm_wr, strobe, match, fire;

  tod_alarm_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .cfg_o      (cfg),
    .alarm_wr_o (alarm_wr)
  );

  tod_alarm_match u_match (
    .cfg_i      (cfg),
    .cur_min_i  (cur_min_i),
    .cur_hour_i (cur_hour_i),
    .cur_wday_i (cur_wday_i),
    .cur_mday_i (cur_mday_i),
    .carry_i    (carry_i),
    .strobe_o   (strobe),
    .match_o    (match)
  );

  tod_alarm_window #(.WIN_CYC(WIN_CYC)) u_window (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strobe_i   (strobe),
    .alarm_wr_i (alarm_wr),
    .match_i    (match),
    .fire_o     (fire)
  );

  tod_alarm_flag u_flag (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fire_i       (fire),
    .flag_we_i    (flag_we_i),
    .flag_wdata_i (flag_wdata_i),
    .irq_en_i     (cfg.irq_en),
    .flag_o       (match_flag_o),
    .irq_no       (irq_no)
  );

  a_r12_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg.irq_en |-> irq_no);
endmodule

// File: tb/tod_alarm_test.sv
module tod_alarm_test;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] cur_min = '0;
  logic [5:0] cur_hour = '0;
  logic [2:0] cur_wday = '0;
  logic [5:0] cur_mday = 6'h01;
  logic       carry = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       flag_we = 1'b0;
  logic       flag_wd = 1'b0;
  logic       flag;
  logic       irq_n;

  int total = 0;
  int fails = 0;
  bit done = 0;

  bit    exp_f[$];
  bit    exp_i[$];
  string exp_t[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tod_alarm #(.WIN_CYC(WIN)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cur_min_i(cur_min), .cur_hour_i(cur_hour), .cur_wday_i(cur_wday), .cur_mday_i(cur_mday),
    .carry_i(carry), .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .flag_we_i(flag_we), .flag_wdata_i(flag_wd),
    .match_flag_o(flag), .irq_no(irq_n)
  );

  // monitor: pops expectations and compares just after the driving edge
  initial forever begin
    @(negedge clk); #1;
    while (exp_f.size() > 0) begin
      bit f, i; string t;
      f = exp_f.pop_front(); i = exp_i.pop_front(); t = exp_t.pop_front();
      total++;
      if (flag !== f || irq_n !== i) begin
        fails++;
        $display("FAIL %s: flag=%b irq_n=%b expected flag=%b irq_n=%b", t, flag, irq_n, f, i);
      end
    end
  end

  task automatic expect_out(input bit f, input bit i, input string t);
    exp_f.push_back(f); exp_i.push_back(i); exp_t.push_back(t);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic fwr(input logic v);
    flag_we = 1'b1; flag_wd = v;
    @(negedge clk);
    flag_we = 1'b0;
  endtask

  task automatic set_time(input logic [6:0] m, input logic [5:0] h, input logic [2:0] w, input logic [5:0] d);
    cur_min = m; cur_hour = h; cur_wday = w; cur_mday = d;
  endtask

  task automatic roll(input logic [6:0] m, input logic [5:0] h, input logic [2:0] w, input logic [5:0] d);
    set_time(m, h, w, d);
    carry = 1'b1;
    @(negedge clk);
    carry = 1'b0;
  endtask

  task automatic settle();
    repeat (WIN) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out(0, 1, "R1 reset state");

    // R7: all fields don't-care after reset
    roll(7'h12, 6'h03, 3'd2, 6'h05); settle();
    expect_out(1, 1, "R7 all don't-care matches; R12 disabled irq released");
    wr(2'd3, 8'h02); @(negedge clk);
    expect_out(1, 0, "R12 irq asserted when enabled");
    fwr(1'b0); @(negedge clk);
    expect_out(0, 1, "R10 clear by writing 0");

    // R8: alarm equal to current time, no strobe
    set_time(7'h30, 6'h07, 3'd1, 6'h09);
    wr(2'd0, 8'h30); wr(2'd1, 8'h07); wr(2'd2, 8'h80);
    repeat (8) @(negedge clk);
    expect_out(0, 1, "R8 equal time without strobe");

    // R2: minute+hour compare
    roll(7'h29, 6'h07, 3'd1, 6'h09); settle();
    expect_out(0, 1, "R2 minute mismatch");
    roll(7'h30, 6'h08, 3'd1, 6'h09); settle();
    expect_out(0, 1, "R2 hour mismatch");
    roll(7'h30, 6'h07, 3'd1, 6'h09);
    repeat (WIN-1) @(negedge clk);
    expect_out(0, 1, "R2 not yet set before window end");
    @(negedge clk);
    expect_out(1, 0, "R2 set at window end");
    fwr(1'b0); @(negedge clk);

    // R3: hour don't-care
    wr(2'd1, 8'h87);
    roll(7'h30, 6'h15, 3'd4, 6'h11); settle();
    expect_out(1, 0, "R3 hour field ignored");

    // R10: sticky, write 1 no effect
    roll(7'h31, 6'h15, 3'd4, 6'h11); settle();
    expect_out(1, 0, "R10 flag holds on later mismatch");
    fwr(1'b1); @(negedge clk);
    expect_out(1, 0, "R10 write of 1 ignored");
    fwr(1'b0); @(negedge clk);
    expect_out(0, 1, "R10 write of 0 clears");

    // R4: week mask days 0 and 6
    wr(2'd0, 8'h45); wr(2'd1, 8'h80); wr(2'd2, 8'h41); wr(2'd3, 8'h02);
    roll(7'h45, 6'h10, 3'd3, 6'h12); settle();
    expect_out(0, 1, "R4 day not in mask");
    roll(7'h45, 6'h10, 3'd6, 6'h12); settle();
    expect_out(1, 0, "R4 day 6 in mask");
    fwr(1'b0);
    roll(7'h45, 6'h10, 3'd0, 6'h13); settle();
    expect_out(1, 0, "R4 day 0 in mask");
    fwr(1'b0);

    // R5: day-of-month mode
    wr(2'd2, 8'h15); wr(2'd3, 8'h03);
    roll(7'h45, 6'h10, 3'd0, 6'h14); settle();
    expect_out(0, 1, "R5 day-of-month mismatch");
    roll(7'h45, 6'h10, 3'd2, 6'h15); settle();
    expect_out(1, 0, "R5 day-of-month match");
    fwr(1'b0);

    // R6: lowest compared digit is hour
    wr(2'd0, 8'h80); wr(2'd1, 8'h09); wr(2'd2, 8'h80); wr(2'd3, 8'h02);
    roll(7'h05, 6'h09, 3'd1, 6'h02); settle();
    expect_out(0, 1, "R6 hour equal but minute not 00");
    roll(7'h00, 6'h09, 3'd1, 6'h02); settle();
    expect_out(1, 0, "R6 hour rollover compares");
    fwr(1'b0);
    // R6: lowest compared digit is week
    wr(2'd1, 8'h80); wr(2'd2, 8'h04);
    roll(7'h00, 6'h05, 3'd2, 6'h02); settle();
    expect_out(0, 1, "R6 week day equal but not day rollover");
    roll(7'h00, 6'h00, 3'd2, 6'h03); settle();
    expect_out(1, 0, "R6 day rollover compares");
    fwr(1'b0);

    // R9: alarm write in window cancels
    wr(2'd0, 8'h10); wr(2'd2, 8'h80);
    roll(7'h10, 6'h04, 3'd1, 6'h02);
    wr(2'd0, 8'h10);
    repeat (WIN-1) @(negedge clk);
    expect_out(0, 1, "R9 write in window cancels compare");
    roll(7'h10, 6'h04, 3'd1, 6'h02);
    @(negedge clk);
    wr(2'd3, 8'h02);
    repeat (WIN-2) @(negedge clk);
    expect_out(1, 0, "R9 config write does not cancel");
    fwr(1'b0);

    // R11: clear on the same edge as the set
    roll(7'h10, 6'h04, 3'd1, 6'h02);
    repeat (WIN-1) @(negedge clk);
    fwr(1'b0);
    expect_out(0, 1, "R11 clear wins over same-edge match");
    @(negedge clk);
    expect_out(0, 1, "R11 flag stays clear afterwards");

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule